// File: doc/BRIEF.md
# Partitioned Exhaustive Key Search Engine

This block recovers a 40-bit secret key for a small iterative challenge-response cipher by trying every key in one slice of the key space. The host places two known challenges, the 24-bit responses each produced under the unknown key, and a 4-bit slice number on the inputs and pulses `start`. Sixteen engines given the sixteen slice numbers cover the whole space between them.

Inside, a row of identical search lanes works in lock step. Each lane has its own cipher core and a fixed lane number. It steps a private counter through its share of the slice. Every candidate is first encrypted against challenge A. Because only 24 of the 40 state bits come back, a match there is often a false positive. So a lane that matches A runs the same key against challenge B before it reports a hit, and its counter waits meanwhile. The first confirmed hit stops every lane and latches the key on `found_key`. If every lane runs out of keys with no confirmation, `exhausted` rises instead.

Top module: `key_search_engine`

## Requirements
- R1: After reset `busy`, `found` and `exhausted` are low and `found_key` is zero.
- R2: A `start` pulse while the engine is not busy captures both challenges, both responses and `part_sel`, and `busy` is high in the following cycle.
- R3: Candidate keys are formed as {slice[3:0], lane index[CORE_W-1:0], zero padding, counter[CNT_W-1:0]} from the most significant bit down. Each lane sweeps its counter from 0 to all-ones, so the slice chosen by `part_sel` is searched completely and no key outside it is tried.
- R4: The cipher loads the challenge into a 40-bit state s and the key into a 40-bit register k, then runs ROUNDS rounds. Each round computes f = s0^s7^k0^(s19&k11)^(s31|k29)^(s3&s23), sets s = {f, s[39:1]} and rotates k left by one ({k[38:0], k39}). The response is s[23:0].
- R5: A candidate whose A response matches but whose B response does not is not reported, and the search carries on.
- R6: When a candidate matches both pairs, `found` rises, `busy` falls, and `found_key` holds that key. Both stay unchanged until the next accepted `start`.
- R7: When no key in the slice matches both pairs, `exhausted` rises, `busy` falls, and `found` stays low.
- R8: A `start` pulse while `busy` is high is ignored. The running search finishes with the operands captured first.
- R9: A key that matches both pairs at the very last counter value of a lane is reported as found, not as exhausted.
- R10: `found` and `exhausted` are never high together, and `busy` only falls with one of them high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search with the values on the operand inputs |
| part_sel | input | PART_W | Slice number (top key bits) |
| chal_a | input | BLK_W | First known challenge |
| resp_a | input | RSP_W | Response observed for the first challenge |
| chal_b | input | BLK_W | Second known challenge |
| resp_b | input | RSP_W | Response observed for the second challenge |
| busy | output | 1 | Search in progress |
| found | output | 1 | A key matching both pairs was found |
| exhausted | output | 1 | Slice searched with no confirmed key |
| found_key | output | BLK_W | The confirmed key |

## Verification
The two outcomes that can meet in one cycle are a lane's confirmation on pair B and the other lanes finishing their last candidates. The bench provokes this by planting the key at the top counter value of the highest lane, so every other lane is spent while that lane's B check is still running. It judges the result as a found key with `exhausted` low. It also plants a key whose B response is deliberately corrupted, so the only A match dies at confirmation. The expected exhausted result comes from a full software sweep of the slice with a bench model of the cipher.

// File: rtl/keysrch_pkg.sv
package keysrch_pkg;

   typedef enum logic [1:0] {
      SR_IDLE  = 2'd0,
      SR_RUN   = 2'd1,
      SR_FOUND = 2'd2,
      SR_EMPTY = 2'd3
   } srch_st_t;

   typedef enum logic [2:0] {
      LN_IDLE  = 3'd0,
      LN_TRY_A = 3'd1,
      LN_TRY_B = 3'd2,
      LN_HIT   = 3'd3,
      LN_SPENT = 3'd4
   } lane_st_t;

endpackage

// File: rtl/ks_cipher.sv
module ks_cipher #(
   parameter int BLK_W  = 40,
   parameter int RSP_W  = 24,
   parameter int ROUNDS = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BLK_W-1:0] chal,
   input  logic [BLK_W-1:0] key,
   output logic             done,
   output logic [RSP_W-1:0] resp
);
   localparam int RC_W = $clog2(ROUNDS + 1);

   generate
      if (BLK_W < 32) begin : g_bad_blk
         $error("ks_cipher: BLK_W must be at least 32");
      end
      if (RSP_W > BLK_W) begin : g_bad_rsp
         $error("ks_cipher: RSP_W exceeds BLK_W");
      end
      if (ROUNDS < 2) begin : g_bad_rounds
         $error("ks_cipher: ROUNDS must be at least 2");
      end
   endgenerate

   logic [BLK_W-1:0] st_q;
   logic [BLK_W-1:0] kr_q;
   logic [RC_W-1:0]  rc_q;
   logic             fb;

   // nonlinear feedback of one round
   always_comb begin
      fb = st_q[0] ^ st_q[7] ^ kr_q[0]
         ^ (st_q[19] & kr_q[11])
         ^ (st_q[31] | kr_q[29])
         ^ (st_q[3]  & st_q[23]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
         kr_q <= '0;
         rc_q <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            st_q <= chal;
            kr_q <= key;
            rc_q <= RC_W'(ROUNDS);
         end else if (rc_q != '0) begin
            st_q <= {fb, st_q[BLK_W-1:1]};
            kr_q <= {kr_q[BLK_W-2:0], kr_q[BLK_W-1]};
            rc_q <= rc_q - 1'b1;
            if (rc_q == RC_W'(1)) begin
               done <= 1'b1;
            end
         end
      end
   end

   assign resp = st_q[RSP_W-1:0];

endmodule

// File: rtl/ks_lane.sv
module ks_lane
   import keysrch_pkg::*;
#(
   parameter int BLK_W  = 40,
   parameter int RSP_W  = 24,
   parameter int ROUNDS = 200,
   parameter int PART_W = 4,
   parameter int CORE_W = 5,
   parameter int CNT_W  = 31,
   parameter int IDX    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              halt,
   input  logic [PART_W-1:0] part,
   input  logic [BLK_W-1:0]  chal_a,
   input  logic [BLK_W-1:0]  chal_b,
   input  logic [RSP_W-1:0]  rsp_a,
   input  logic [RSP_W-1:0]  rsp_b,
   output logic              hit,
   output logic              spent,
   output logic [BLK_W-1:0]  cand_key
);
   localparam int PAD_W = BLK_W - PART_W - CORE_W - CNT_W;
   localparam logic [CORE_W-1:0] IDX_V = CORE_W'(IDX);

   lane_st_t         ln_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fire_q;
   logic             cdone;
   logic [RSP_W-1:0] cresp;
   logic [BLK_W-1:0] cchal;

   generate
      if (PAD_W > 0) begin : g_pad
         assign cand_key = {part, IDX_V, {PAD_W{1'b0}}, cnt_q};
      end else begin : g_nopad
         assign cand_key = {part, IDX_V, cnt_q};
      end
   endgenerate

   assign cchal = (ln_q == LN_TRY_B) ? chal_b : chal_a;

   ks_cipher #(
      .BLK_W (BLK_W),
      .RSP_W (RSP_W),
      .ROUNDS(ROUNDS)
   ) u_cipher (
      .clk  (clk),
      .rst_n(rst_n),
      .load (fire_q),
      .chal (cchal),
      .key  (cand_key),
      .done (cdone),
      .resp (cresp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ln_q   <= LN_IDLE;
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (go) begin
            ln_q   <= LN_TRY_A;
            cnt_q  <= '0;
            fire_q <= 1'b1;
         end else if (halt) begin
            if (ln_q == LN_TRY_A || ln_q == LN_TRY_B) begin
               ln_q <= LN_IDLE;
            end
         end else if (cdone && !fire_q) begin
            if (ln_q == LN_TRY_A && cresp == rsp_a) begin
               ln_q   <= LN_TRY_B;
               fire_q <= 1'b1;
            end else if (ln_q == LN_TRY_B && cresp == rsp_b) begin
               ln_q <= LN_HIT;
            end else if (ln_q == LN_TRY_A || ln_q == LN_TRY_B) begin
               if (cnt_q == '1) begin
                  ln_q <= LN_SPENT;
               end else begin
                  cnt_q  <= cnt_q + 1'b1;
                  ln_q   <= LN_TRY_A;
                  fire_q <= 1'b1;
               end
            end
         end
      end
   end

   assign hit   = (ln_q == LN_HIT);
   assign spent = (ln_q == LN_SPENT);

endmodule

// File: rtl/key_search_engine.sv
module key_search_engine
   import keysrch_pkg::*;
#(
   parameter int BLK_W  = 40,
   parameter int RSP_W  = 24,
   parameter int ROUNDS = 200,
   parameter int PART_W = 4,
   parameter int CORE_W = 5,
   parameter int CNT_W  = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PART_W-1:0] part_sel,
   input  logic [BLK_W-1:0]  chal_a,
   input  logic [RSP_W-1:0]  resp_a,
   input  logic [BLK_W-1:0]  chal_b,
   input  logic [RSP_W-1:0]  resp_b,
   output logic              busy,
   output logic              found,
   output logic              exhausted,
   output logic [BLK_W-1:0]  found_key
);
   localparam int NL = 1 << CORE_W;

   generate
      if (PART_W + CORE_W + CNT_W > BLK_W) begin : g_bad_split
         $error("key_search_engine: key fields exceed BLK_W");
      end
      if (CNT_W < 1 || CORE_W < 1 || PART_W < 1) begin : g_bad_field
         $error("key_search_engine: every key field needs a bit");
      end
   endgenerate

   srch_st_t          st_q;
   logic              go_q;
   logic [PART_W-1:0] part_q;
   logic [BLK_W-1:0]  ca_q, cb_q;
   logic [RSP_W-1:0]  ra_q, rb_q;
   logic [BLK_W-1:0]  key_q;

   logic [NL-1:0]     hit_vec;
   logic [NL-1:0]     spent_vec;
   logic [BLK_W-1:0]  lane_key [NL];
   logic [BLK_W-1:0]  sel_key;
   logic              halt;

   assign halt = (st_q != SR_RUN);

   for (genvar g = 0; g < NL; g++) begin : g_lane
      ks_lane #(
         .BLK_W (BLK_W),
         .RSP_W (RSP_W),
         .ROUNDS(ROUNDS),
         .PART_W(PART_W),
         .CORE_W(CORE_W),
         .CNT_W (CNT_W),
         .IDX   (g)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .go      (go_q),
         .halt    (halt),
         .part    (part_q),
         .chal_a  (ca_q),
         .chal_b  (cb_q),
         .rsp_a   (ra_q),
         .rsp_b   (rb_q),
         .hit     (hit_vec[g]),
         .spent   (spent_vec[g]),
         .cand_key(lane_key[g])
      );
   end

   // lowest lane wins when several confirm together
   always_comb begin
      sel_key = '0;
      for (int i = NL - 1; i >= 0; i--) begin
         if (hit_vec[i]) sel_key = lane_key[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SR_IDLE;
         go_q   <= 1'b0;
         part_q <= '0;
         ca_q   <= '0;
         cb_q   <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
         key_q  <= '0;
      end else begin
         go_q <= 1'b0;
         if (st_q != SR_RUN) begin
            if (start) begin
               st_q   <= SR_RUN;
               go_q   <= 1'b1;
               part_q <= part_sel;
               ca_q   <= chal_a;
               cb_q   <= chal_b;
               ra_q   <= resp_a;
               rb_q   <= resp_b;
            end
         end else if (!go_q) begin
            if (|hit_vec) begin
               st_q  <= SR_FOUND;
               key_q <= sel_key;
            end else if (&spent_vec) begin
               st_q <= SR_EMPTY;
            end
         end
      end
   end

   assign busy      = (st_q == SR_RUN);
   assign found     = (st_q == SR_FOUND);
   assign exhausted = (st_q == SR_EMPTY);
   assign found_key = key_q;

endmodule

module ks_search_chk #(
   parameter int BLK_W = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             found,
   input logic             exhausted,
   input logic [BLK_W-1:0] found_key
);
   // R10
   outcome_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && exhausted));

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R6
   found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (found && !start) |=> (found && $stable(found_key)));

   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (found || exhausted));

   // R7
   empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> (!busy && !found));

   // R8
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || found || exhausted));

endmodule

bind key_search_engine ks_search_chk #(.BLK_W(BLK_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .found    (found),
   .exhausted(exhausted),
   .found_key(found_key)
);

// File: tb/sim_key_search_engine.sv
`timescale 1ns/1ps
module sim_key_search_engine;
   localparam int BLK_W  = 40;
   localparam int RSP_W  = 24;
   localparam int ROUNDS = 200;
   localparam int PART_W = 4;
   localparam int CORE_W = 2;
   localparam int CNT_W  = 4;
   localparam int NL     = 1 << CORE_W;
   localparam int NC     = 1 << CNT_W;
   localparam int PAD_W  = BLK_W - PART_W - CORE_W - CNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [PART_W-1:0] part_sel = '0;
   logic [BLK_W-1:0]  chal_a = '0, chal_b = '0;
   logic [RSP_W-1:0]  resp_a = '0, resp_b = '0;
   logic              busy, found, exhausted;
   logic [BLK_W-1:0]  found_key;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   key_search_engine #(
      .BLK_W(BLK_W), .RSP_W(RSP_W), .ROUNDS(ROUNDS),
      .PART_W(PART_W), .CORE_W(CORE_W), .CNT_W(CNT_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .part_sel(part_sel),
      .chal_a(chal_a), .resp_a(resp_a), .chal_b(chal_b), .resp_b(resp_b),
      .busy(busy), .found(found), .exhausted(exhausted), .found_key(found_key)
   );

   // cipher model written from R4
   function automatic logic [RSP_W-1:0] enc(input logic [39:0] c, input logic [39:0] k);
      logic [39:0] s = c;
      logic [39:0] r = k;
      logic        f;
      for (int i = 0; i < ROUNDS; i++) begin
         f = s[0] ^ s[7] ^ r[0] ^ (s[19] & r[11]) ^ (s[31] | r[29]) ^ (s[3] & s[23]);
         s = {f, s[39:1]};
         r = {r[38:0], r[39]};
      end
      return s[23:0];
   endfunction

   // key layout from R3
   function automatic logic [39:0] mk(input int p, input int ln, input int c);
      return {PART_W'(p), CORE_W'(ln), {PAD_W{1'b0}}, CNT_W'(c)};
   endfunction

   // sweep one slice; returns count of full matches and the first one
   function automatic int sweep(input int p, input logic [39:0] ca, input logic [23:0] ra,
                                input logic [39:0] cb, input logic [23:0] rb,
                                output logic [39:0] first);
      int n = 0;
      first = '0;
      for (int c = 0; c < NC; c++) begin
         for (int ln = 0; ln < NL; ln++) begin
            if (enc(ca, mk(p, ln, c)) == ra && enc(cb, mk(p, ln, c)) == rb) begin
               if (n == 0) first = mk(p, ln, c);
               n++;
            end
         end
      end
      return n;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic launch(input int p, input logic [39:0] ca, input logic [23:0] ra,
                         input logic [39:0] cb, input logic [23:0] rb);
      @(negedge clk);
      part_sel = PART_W'(p); chal_a = ca; resp_a = ra; chal_b = cb; resp_b = rb;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
   endtask

   task automatic wait_end(output bit ok);
      int t = 0;
      ok = 1'b1;
      while (!(found || exhausted)) begin
         @(negedge clk);
         t++;
         if (t > 40000) begin
            ok = 1'b0;
            break;
         end
      end
      chk(ok, "watchdog search end", 64'(t), 64'd40000);
   endtask

   // run a search and compare against the bench sweep
   task automatic run_case(input string req, input int p, input logic [39:0] ca, input logic [23:0] ra,
                           input logic [39:0] cb, input logic [23:0] rb);
      logic [39:0] exp_k;
      int          n;
      bit          ok;
      n = sweep(p, ca, ra, cb, rb, exp_k);
      launch(p, ca, ra, cb, rb);
      wait_end(ok);
      if (n == 0) begin
         chk(exhausted === 1'b1 && found === 1'b0 && busy === 1'b0,
             {req, " R7 exhausted"}, {61'd0, busy, found, exhausted}, 64'd1);
      end else begin
         chk(found === 1'b1 && exhausted === 1'b0 && busy === 1'b0,
             {req, " R6 found flags"}, {61'd0, busy, found, exhausted}, 64'd2);
         if (n == 1) begin
            chk(found_key === exp_k, {req, " R6 found key"}, 64'(found_key), 64'(exp_k));
         end else begin
            chk(enc(ca, found_key) == ra && enc(cb, found_key) == rb && found_key[39:36] == PART_W'(p),
                {req, " R6 found key valid"}, 64'(found_key), 64'(exp_k));
         end
      end
   endtask

   task automatic plant(input string req, input int p, input int ln, input int c, input bit spoil_b);
      logic [39:0] k;
      logic [39:0] ca, cb;
      logic [23:0] rb;
      k  = mk(p, ln, c);
      ca = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      cb = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      rb = enc(cb, k) ^ (spoil_b ? 24'h000001 : 24'h0);
      run_case(req, p, ca, enc(ca, k), cb, rb);
   endtask

   initial begin
      void'($urandom(32'h0C0FFEE5));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(busy === 1'b0 && found === 1'b0 && exhausted === 1'b0, "R1 reset flags",
          {61'd0, busy, found, exhausted}, 64'd0);
      chk(found_key === '0, "R1 reset key", 64'(found_key), 64'd0);

      // R3 first key of slice; R4 model agreement
      plant("R3 R4 lane0 cnt0", 5, 0, 0, 1'b0);
      // R9 last key of last lane: confirmation meets exhaustion of others
      plant("R9 last key", 9, NL - 1, NC - 1, 1'b0);
      // R5 pair-A false positive must not stop the search
      plant("R5 spoiled B", 3, 1, 7, 1'b1);
      // R3 slice restriction: key planted in slice 6, search slice 7
      begin
         logic [39:0] k, ca, cb;
         k  = mk(6, 2, 4);
         ca = 40'h12_3456_789A;
         cb = 40'hFE_DCBA_9876;
         run_case("R3 other slice", 7, ca, enc(ca, k), cb, enc(cb, k));
      end

      // R8 start while busy is ignored
      begin
         logic [39:0] k, ca, cb, k2;
         bit ok;
         k  = mk(12, 1, 10);
         k2 = mk(2, 3, 1);
         ca = 40'h0A_5A5A_5A5A;
         cb = 40'h05_A5A5_A5A5;
         launch(12, ca, enc(ca, k), cb, enc(cb, k));
         repeat (50) @(negedge clk);
         part_sel = 4'd2; resp_a = enc(ca, k2); resp_b = enc(cb, k2);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_end(ok);
         chk(found === 1'b1 && found_key === k, "R8 restart ignored", 64'(found_key), 64'(k));
         // R6 hold while idle
         repeat (20) @(negedge clk);
         chk(found === 1'b1 && found_key === k, "R6 hold", 64'(found_key), 64'(k));
      end

      // random plants
      for (int i = 0; i < 6; i++) begin
         plant("R3 R6 random", int'($urandom_range(15, 0)), int'($urandom_range(NL - 1, 0)),
               int'($urandom_range(NC - 1, 0)), 1'b0);
      end
      // random spoiled plant, then no-key random pairs
      plant("R5 random spoiled", int'($urandom_range(15, 0)), int'($urandom_range(NL - 1, 0)),
            int'($urandom_range(NC - 1, 0)), 1'b1);
      run_case("R7 random pairs", int'($urandom_range(15, 0)),
               {$urandom, $urandom} & 40'hFF_FFFF_FFFF, 24'($urandom),
               {$urandom, $urandom} & 40'hFF_FFFF_FFFF, 24'($urandom));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL global watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule